// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Block

This block is a programmable logic cell. It has a bank of macrocells, and each macrocell forms a sum of product terms over a shared input bus. A product term can use each input in true or complemented form. Each macrocell owns a few product terms whose OR is fixed. It can also add any subset of a pool of shared product terms through a fully programmable OR plane. The sum is either driven straight out or captured in a flip-flop. A small set of control terms supplies the asynchronous preset, the asynchronous reset and the output enable of every macrocell. Each control term is set up on its own to be a product or a sum of its chosen literals.

All planes and options live in one configuration vector, and that vector is loaded serially before use. While loading is in progress, every output enable is held low and the flip-flops keep their state. After loading, the block is purely a function of its inputs, the clock and the flip-flop state. The default size is 36 inputs, 16 macrocells, 5 dedicated terms per macrocell, a 32-term shared pool and 6 control terms. Every dimension is a parameter.

Top module: `clb_logic_block`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge moves configuration bit k to bit k+1 and loads `cfg_din` into bit 0, so the first bit sent ends in bit CFG_W-1. While `cfg_en` is low the vector does not change. `rst_n` low clears the vector and every macrocell flip-flop.
- R2: Configuration fields, counted up from bit 0, with L = 2*N_IN:
  - The dedicated AND masks: macrocell m, term t at (m*N_PT+t)*L.
  - The shared AND masks: shared term s at S0 + s*L, where S0 = N_MC*N_PT*L.
  - The OR plane at S1 = S0 + N_SH*L: macrocell m, shared term s at bit m*N_SH+s.
  - The control terms at S2 = S1 + N_MC*N_SH, with stride L+1. Each is an L-bit mask followed by a mode bit.
  - The macrocell words at S2 + N_CT*(L+1), with stride 1+3*SEL_W. Within a word, bit 0 selects registered output, then come the preset selector, the reset selector and the output-enable selector, in that order.
- R3: In every mask, bit 2i selects input i and bit 2i+1 selects its complement. A product term is the AND of its selected literals and is 0 when its mask is empty.
- R4: A macrocell's sum is the OR of its N_PT dedicated terms and of each shared term whose OR-plane bit is set for that macrocell. A shared term whose OR-plane bit is clear has no effect on that sum.
- R5: A control term whose mode bit is 1 is the OR of its selected literals. With mode bit 0 it is their AND. With an empty mask it is 0 in both modes.
- R6: A selector code c below N_CT picks control term c. The all-ones code gives a constant 1, and every other code gives a constant 0. `mc_oe` of a macrocell is the value of its output-enable selector whenever `cfg_en` is low.
- R7: With the registered bit set, `mc_dout` is a flip-flop that captures the sum on the rising clock edge. With the bit clear, `mc_dout` follows the sum combinationally.
- R8: Preset and reset act on the flip-flop without waiting for a clock. Reset forces 0. A rising preset forces 1. When both are active, reset wins. A preset still held when reset is released leaves 0 until the next rising clock edge, which loads 1.
- R9: While `cfg_en` is high, every `mc_oe` is low, and the flip-flops neither load on the clock nor respond to preset or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain and the macrocell flip-flops |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration and the flip-flops |
| cfg_en | input | 1 | High while the configuration is shifted in |
| cfg_din | input | 1 | Serial configuration data, most significant bit first |
| lb_in | input | N_IN | Logic inputs to all product and control terms |
| mc_dout | output | N_MC | Macrocell data outputs |
| mc_oe | output | N_MC | Macrocell output enables |

## Verification
The bench uses a reduced block with three inputs, so every input vector is applied under every configuration. Each sweep runs once in ascending order and once in descending order. The two orders give the asynchronous preset and reset different rising and falling histories. This separates reset priority from clock capture and from preset edges.

Forty random configurations load sparse masks, random term modes and random selector codes. These vary how the dedicated terms, the shared terms and the control terms mix. A hand-built configuration then gives each macrocell one known function:
- an AND with a complemented literal;
- a sum drawn from one dedicated term and one shared term, while another shared term sits unselected;
- a sum-mode output enable;
- a registered output with conflicting preset and reset.

These single out literal polarity, OR-plane selection and term mode. Loading with outputs observed separates the hold behaviour from normal operation, and a final reset shows that the configuration is cleared.

// File: rtl/clb_pkg.sv
`timescale 1ns/1ps
package clb_pkg;

   // How a term combines its selected literals
   typedef enum logic {
      TK_PROD = 1'b0,
      TK_SUM  = 1'b1
   } term_kind_e;

   // Total configuration width for a given block geometry
   function automatic int clb_cfg_width(input int n_in, input int n_mc, input int n_pt,
                                        input int n_sh, input int n_ct, input int sel_w);
      int lit_w;
      lit_w = 2 * n_in;
      return n_mc * n_pt * lit_w + n_sh * lit_w + n_mc * n_sh
           + n_ct * (lit_w + 1) + n_mc * (1 + 3 * sel_w);
   endfunction

endpackage

// File: rtl/clb_cfg_chain.sv
`timescale 1ns/1ps
module clb_cfg_chain #(
   parameter int CFG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             din,
   output logic [CFG_W-1:0] cfg_q
);

   if (CFG_W < 2) begin : g_bad_width
      $error("clb_cfg_chain: CFG_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= '0;
      else if (shift_en) cfg_q <= {cfg_q[CFG_W-2:0], din};
   end

   // R1: the new bit enters at the bottom
   p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> cfg_q[0] == $past(din));

   // R1: nothing moves while loading is off
   p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(cfg_q));

endmodule

// File: rtl/clb_term.sv
`timescale 1ns/1ps
module clb_term #(
   parameter int N_LIT = 4
) (
   input  logic [N_LIT-1:0]   mask,
   input  logic [N_LIT-1:0]   lits,
   input  clb_pkg::term_kind_e kind,
   output logic               y
);

   logic any_sel;
   logic all_hit;
   logic one_hit;

   assign any_sel = |mask;
   assign all_hit = &(lits | ~mask);
   assign one_hit = |(lits & mask);

   always_comb begin
      if (kind == clb_pkg::TK_SUM) y = one_hit;
      else                         y = any_sel & all_hit;
   end

endmodule

// File: rtl/clb_macrocell.sv
`timescale 1ns/1ps
module clb_macrocell #(
   parameter int N_PT  = 5,
   parameter int N_SH  = 32,
   parameter int N_CT  = 6,
   parameter int SEL_W = 3,
   localparam int WORD_W = 1 + 3 * SEL_W,
   localparam int CODES  = 1 << SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic [N_PT-1:0]   ded_y,
   input  logic [N_SH-1:0]   shr_y,
   input  logic [N_SH-1:0]   or_sel,
   input  logic [N_CT-1:0]   ctl_y,
   input  logic [WORD_W-1:0] word,
   output logic              dout,
   output logic              oe
);

   if (N_CT > CODES - 1) begin : g_bad_codes
      $error("clb_macrocell: selector too narrow for N_CT control terms");
   end

   logic             reg_mode;
   logic [SEL_W-1:0] pre_sel;
   logic [SEL_W-1:0] clr_sel;
   logic [SEL_W-1:0] oe_sel;
   logic [CODES-1:0] ctl_ext;
   logic             sum;
   logic             pre_t;
   logic             clr_t;
   logic             oe_t;
   logic             clr_a;
   logic             set_a;
   logic             q;

   assign reg_mode = word[0];
   assign pre_sel  = word[SEL_W:1];
   assign clr_sel  = word[2*SEL_W:SEL_W+1];
   assign oe_sel   = word[3*SEL_W:2*SEL_W+1];

   // Codes past the real terms are constant 0, the top code constant 1
   always_comb begin
      ctl_ext            = '0;
      ctl_ext[N_CT-1:0]  = ctl_y;
      ctl_ext[CODES-1]   = 1'b1;
   end

   assign pre_t = ctl_ext[pre_sel];
   assign clr_t = ctl_ext[clr_sel];
   assign oe_t  = ctl_ext[oe_sel];

   assign sum   = (|ded_y) | (|(shr_y & or_sel));

   assign clr_a = ~rst_n | (clr_t & ~hold);
   assign set_a = pre_t & ~hold;

   always_ff @(posedge clk or posedge clr_a or posedge set_a) begin
      if (clr_a)      q <= 1'b0;
      else if (set_a) q <= 1'b1;
      else if (!hold) q <= sum;
   end

   assign dout = reg_mode ? q : sum;
   assign oe   = oe_t & ~hold;

   // R8: an active reset leaves the flop at 0
   p_reset_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_a |-> q == 1'b0);

   // R8: preset without reset gives 1 by the next edge
   p_preset_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_a && !clr_a) |=> (clr_a || q));

   // R7: plain clock edge captures the sum
   p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !clr_a && !set_a) |=> (clr_a || set_a || q == $past(sum)));

   // R9: flop is frozen while loading
   p_hold_flop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (!hold || $stable(q)));

endmodule

// File: rtl/clb_logic_block.sv
`timescale 1ns/1ps
module clb_logic_block #(
   parameter int N_IN  = 36,
   parameter int N_MC  = 16,
   parameter int N_PT  = 5,
   parameter int N_SH  = 32,
   parameter int N_CT  = 6,
   parameter int SEL_W = 3,
   localparam int LIT_W     = 2 * N_IN,
   localparam int DED_OFS   = 0,
   localparam int SHR_OFS   = DED_OFS + N_MC * N_PT * LIT_W,
   localparam int ORP_OFS   = SHR_OFS + N_SH * LIT_W,
   localparam int CT_OFS    = ORP_OFS + N_MC * N_SH,
   localparam int CT_STRIDE = LIT_W + 1,
   localparam int MC_OFS    = CT_OFS + N_CT * CT_STRIDE,
   localparam int MC_STRIDE = 1 + 3 * SEL_W,
   localparam int CFG_W     = MC_OFS + N_MC * MC_STRIDE
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_en,
   input  logic            cfg_din,
   input  logic [N_IN-1:0] lb_in,
   output logic [N_MC-1:0] mc_dout,
   output logic [N_MC-1:0] mc_oe
);

   import clb_pkg::*;

   if (N_IN < 1 || N_MC < 1 || N_PT < 1 || N_SH < 1 || N_CT < 1) begin : g_bad_dims
      $error("clb_logic_block: every dimension must be at least 1");
   end
   if (CFG_W != clb_cfg_width(N_IN, N_MC, N_PT, N_SH, N_CT, SEL_W)) begin : g_bad_layout
      $error("clb_logic_block: configuration layout mismatch");
   end

   logic [CFG_W-1:0] cfg;
   logic [LIT_W-1:0] lits;
   logic [N_PT-1:0]  ded_y [N_MC];
   logic [N_SH-1:0]  shr_y;
   logic [N_CT-1:0]  ctl_y;

   clb_cfg_chain #(.CFG_W(CFG_W)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cfg_en),
      .din      (cfg_din),
      .cfg_q    (cfg)
   );

   // True and complement literal for every input
   for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lits[2*i]   = lb_in[i];
      assign lits[2*i+1] = ~lb_in[i];
   end

   // Shared pool, fixed as products
   for (genvar s = 0; s < N_SH; s++) begin : g_shr
      clb_term #(.N_LIT(LIT_W)) u_term (
         .mask (cfg[SHR_OFS + s*LIT_W +: LIT_W]),
         .lits (lits),
         .kind (TK_PROD),
         .y    (shr_y[s])
      );
   end

   // Control terms, each with its own mode bit
   for (genvar c = 0; c < N_CT; c++) begin : g_ctl
      clb_term #(.N_LIT(LIT_W)) u_term (
         .mask (cfg[CT_OFS + c*CT_STRIDE +: LIT_W]),
         .lits (lits),
         .kind (term_kind_e'(cfg[CT_OFS + c*CT_STRIDE + LIT_W])),
         .y    (ctl_y[c])
      );
   end

   for (genvar m = 0; m < N_MC; m++) begin : g_mc
      for (genvar t = 0; t < N_PT; t++) begin : g_ded
         clb_term #(.N_LIT(LIT_W)) u_term (
            .mask (cfg[DED_OFS + (m*N_PT + t)*LIT_W +: LIT_W]),
            .lits (lits),
            .kind (TK_PROD),
            .y    (ded_y[m][t])
         );
      end

      clb_macrocell #(
         .N_PT  (N_PT),
         .N_SH  (N_SH),
         .N_CT  (N_CT),
         .SEL_W (SEL_W)
      ) u_mc (
         .clk    (clk),
         .rst_n  (rst_n),
         .hold   (cfg_en),
         .ded_y  (ded_y[m]),
         .shr_y  (shr_y),
         .or_sel (cfg[ORP_OFS + m*N_SH +: N_SH]),
         .ctl_y  (ctl_y),
         .word   (cfg[MC_OFS + m*MC_STRIDE +: MC_STRIDE]),
         .dout   (mc_dout[m]),
         .oe     (mc_oe[m])
      );
   end

   // R9: no enable leaves the block while loading
   p_oe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |-> mc_oe == '0);

endmodule

// File: tb/tb_clb_logic_block.sv
`timescale 1ns/1ps
module tb_clb_logic_block;

   localparam int NI  = 3;
   localparam int NM  = 4;
   localparam int NP  = 2;
   localparam int NS  = 4;
   localparam int NC  = 6;
   localparam int SW  = 3;
   localparam int LW  = 2 * NI;
   localparam int S0  = NM * NP * LW;
   localparam int S1  = S0 + NS * LW;
   localparam int S2  = S1 + NM * NS;
   localparam int CTS = LW + 1;
   localparam int S3  = S2 + NC * CTS;
   localparam int MCS = 1 + 3 * SW;
   localparam int CW  = S3 + NM * MCS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_en = 1'b0;
   logic          cfg_din = 1'b0;
   logic [NI-1:0] lb_in = '0;
   logic [NM-1:0] mc_dout;
   logic [NM-1:0] mc_oe;

   int checks = 0;
   int failures = 0;

   logic [CW-1:0] cfg_v;
   logic          q_exp [NM];
   logic          prev_set [NM];

   always #2 clk = ~clk;

   clb_logic_block #(
      .N_IN(NI), .N_MC(NM), .N_PT(NP), .N_SH(NS), .N_CT(NC), .SEL_W(SW)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
      .lb_in(lb_in), .mc_dout(mc_dout), .mc_oe(mc_oe)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // Reference model built from the requirement text
   function automatic logic lit_on(input int k, input logic [NI-1:0] v);
      return (k % 2 == 0) ? v[k/2] : ~v[k/2];
   endfunction

   function automatic logic term_val(input int base, input logic is_sum, input logic [NI-1:0] v);
      logic any = 1'b0, all = 1'b1, hit = 1'b0;
      for (int k = 0; k < LW; k++) begin
         if (cfg_v[base+k]) begin
            any = 1'b1;
            if (lit_on(k, v)) hit = 1'b1;
            else              all = 1'b0;
         end
      end
      return is_sum ? hit : (any & all);
   endfunction

   function automatic logic sel_val(input int code, input logic [NI-1:0] v);
      if (code == (1 << SW) - 1) return 1'b1;
      if (code < NC) return term_val(S2 + code*CTS, cfg_v[S2 + code*CTS + LW], v);
      return 1'b0;
   endfunction

   function automatic int fld(input int m, input int k);
      return int'(cfg_v[S3 + m*MCS + 1 + k*SW +: SW]);
   endfunction

   function automatic logic mc_sum(input int m, input logic [NI-1:0] v);
      logic s = 1'b0;
      for (int t = 0; t < NP; t++) s |= term_val((m*NP + t)*LW, 1'b0, v);
      for (int h = 0; h < NS; h++)
         if (cfg_v[S1 + m*NS + h]) s |= term_val(S0 + h*LW, 1'b0, v);
      return s;
   endfunction

   task automatic set_word(input int m, input logic rg, input int pre, input int rst, input int oe);
      cfg_v[S3 + m*MCS] = rg;
      cfg_v[S3 + m*MCS + 1      +: SW] = SW'(pre);
      cfg_v[S3 + m*MCS + 1 + SW +: SW] = SW'(rst);
      cfg_v[S3 + m*MCS + 1 + 2*SW +: SW] = SW'(oe);
   endtask

   // Starts and ends at a falling edge
   task automatic load_cfg();
      for (int i = CW - 1; i >= 0; i--) begin
         cfg_en  = 1'b1;
         cfg_din = cfg_v[i];
         @(posedge clk);
         @(negedge clk);
         chk("R9 oe low while loading", |mc_oe, 1'b0);
      end
      cfg_en = 1'b0;
      for (int m = 0; m < NM; m++) prev_set[m] = 1'b0;
   endtask

   // Apply one vector at a falling edge, check before and after the next rising edge
   task automatic step(input logic [NI-1:0] v);
      logic clr_e, set_e, s;
      lb_in = v;
      #1;
      for (int m = 0; m < NM; m++) begin
         clr_e = sel_val(fld(m, 1), v);
         set_e = sel_val(fld(m, 0), v);
         if (clr_e)                       q_exp[m] = 1'b0;
         else if (set_e && !prev_set[m])  q_exp[m] = 1'b1;
         prev_set[m] = set_e;
         s = mc_sum(m, v);
         if (cfg_v[S3 + m*MCS]) chk("R8 async preset/reset", mc_dout[m], q_exp[m]);
         else                   chk("R4 combinational sum", mc_dout[m], s);
         chk("R6 output enable select", mc_oe[m], sel_val(fld(m, 2), v));
      end
      @(posedge clk);
      #1;
      for (int m = 0; m < NM; m++) begin
         clr_e = sel_val(fld(m, 1), v);
         set_e = sel_val(fld(m, 0), v);
         s = mc_sum(m, v);
         q_exp[m] = clr_e ? 1'b0 : (set_e ? 1'b1 : s);
         chk("R7 output after edge", mc_dout[m], cfg_v[S3 + m*MCS] ? q_exp[m] : s);
      end
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      cfg_v = '0;
      for (int m = 0; m < NM; m++) begin q_exp[m] = 1'b0; prev_set[m] = 1'b0; end
      repeat (3) @(negedge clk);
      chk("R1 reset dout", |mc_dout, 1'b0);
      chk("R1 reset oe", |mc_oe, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // Directed configuration, laid out per R2
      cfg_v = '0;
      cfg_v[0] = 1'b1;  cfg_v[3] = 1'b1;              // mc0: in0 & ~in1
      set_word(0, 1'b0, 6, 6, 7);
      cfg_v[(1*NP + 1)*LW + 4] = 1'b1;                // mc1 dedicated: in2
      cfg_v[S0 + 2*LW + 1] = 1'b1;                    // shared 2: ~in0
      cfg_v[S1 + 1*NS + 2] = 1'b1;                    // mc1 uses shared 2
      set_word(1, 1'b0, 6, 6, 7);
      cfg_v[S0 + 0*LW + 2] = 1'b1;                    // shared 0: in1, unused by mc2
      cfg_v[S2 + 2*CTS + 0] = 1'b1;
      cfg_v[S2 + 2*CTS + 2] = 1'b1;
      cfg_v[S2 + 2*CTS + LW] = 1'b1;                  // ct2 = in0 | in1
      set_word(2, 1'b0, 6, 6, 2);
      cfg_v[(3*NP)*LW + 4] = 1'b1;                    // mc3 dedicated: in2
      cfg_v[S2 + 0*CTS + 0] = 1'b1;
      cfg_v[S2 + 0*CTS + 2] = 1'b1;                   // ct0 = in0 & in1 (preset)
      cfg_v[S2 + 1*CTS + 0] = 1'b1;
      cfg_v[S2 + 1*CTS + 5] = 1'b1;                   // ct1 = in0 & ~in2 (reset)
      set_word(3, 1'b1, 0, 1, 7);
      load_cfg();
      for (int pass = 0; pass < 2; pass++) begin
         for (int j = 0; j < 8; j++) begin
            logic [NI-1:0] v;
            logic a, b, c;
            v = NI'(pass == 0 ? j : 7 - j);
            a = v[0]; b = v[1]; c = v[2];
            step(v);
            chk("R2 R3 literal polarity", mc_dout[0], a & ~b);
            chk("R4 dedicated plus shared", mc_dout[1], c | ~a);
            chk("R4 unselected shared ignored", mc_dout[2], 1'b0);
            chk("R5 sum-mode control term", mc_oe[2], a | b);
            chk("R6 all-ones code", mc_oe[0], 1'b1);
            if ((a & ~c) && (a & b)) chk("R8 reset beats preset", mc_dout[3], 1'b0);
            else chk("R7 registered capture", mc_dout[3], (a & ~c) ? 1'b0 : ((a & b) ? 1'b1 : c));
         end
      end

      // Random configurations, full sweeps both ways
      for (int n = 0; n < 40; n++) begin
         for (int i = 0; i < CW; i++) cfg_v[i] = (($urandom % 4) == 0);
         for (int c = 0; c < NC; c++) cfg_v[S2 + c*CTS + LW] = 1'($urandom % 2);
         for (int m = 0; m < NM; m++)
            set_word(m, 1'($urandom % 2),
                     (($urandom % 3) == 0) ? int'($urandom % 8) : 6,
                     (($urandom % 3) == 0) ? int'($urandom % 8) : 6,
                     int'($urandom % 8));
         load_cfg();
         for (int j = 0; j < 8; j++) step(NI'(j));
         for (int j = 7; j >= 0; j--) step(NI'(j));
      end

      // Reset clears the configuration
      rst_n = 1'b0;
      #1;
      chk("R1 reset clears dout", |mc_dout, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      lb_in = '1;
      #1;
      chk("R1 cleared config gives no enable", |mc_oe, 1'b0);
      chk("R1 cleared config gives no sum", |mc_dout, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule